// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped first-level cache. It keeps the lines that cache has recently thrown out. Addresses that conflict in the direct-mapped array evict one another from the same slot. The buffer keeps those discarded lines close at hand, so it adds associativity to the few indices that thrash. Every line the primary cache evicts is offered on the insert port. When the primary cache misses, it presents the line address on the lookup port, and the buffer is searched before anything goes to the next level.

All entries are compared at once. On a match, the buffer returns the stored line and its dirty state. In the same cycle it takes in the line the primary cache is evicting for that index, so the two lines swap places. If the primary cache has nothing to evict, the matched entry is emptied.

On a miss, the evicted line is pushed in round-robin order, and the oldest entry is overwritten. If the overwritten entry was dirty, it is first written back to the next level. After that, a read for the missing line is issued. The block reports busy until the next level signals completion, and then returns the fetched line.

Top module: `victimCache`

## Requirements
- R1: After reset the buffer holds no lines, `busy`, `nlReq` and `respValid` are low, and the first lookup misses.
- R2: A line pushed on the insert port while idle is found by a later lookup of its address. `respValid` and `respHit` are high in the cycle after the lookup, `respData`/`respDirty` equal the stored line, and `nlReq` stays low.
- R3: On a hit with `insValid` high, the matched entry is replaced by the inserted line. A later lookup of the inserted address hits, and a later lookup of the returned address misses.
- R4: On a hit with `insValid` low, the matched entry is emptied, so a second lookup of the same address misses.
- R5: On a miss, from the next cycle until `nlDone`, `busy` and `nlReq` are high with `nlWrite`=0 and `nlAddr` equal to the looked-up address. In the cycle after `nlDone`, `respValid`=1, `respHit`=0, `respData`=`nlRdata`, `respDirty`=0 and `busy`=0.
- R6: Pushed lines fill the ENTRIES slots (4 or 8) in a fixed rotating order. Once all slots are full, a push overwrites the line that was pushed earliest, which then misses.
- R7: When a push overwrites a valid dirty line, a writeback (`nlWrite`=1, `nlAddr`/`nlWdata` equal to the overwritten line) completes before the read of R5. Overwriting a clean line causes no writeback.
- R8: While `busy` is high, `lookupValid` and `insValid` are ignored: nothing is stored and `nlAddr` is unchanged.
- R9: A push with no lookup that overwrites a dirty line performs only the writeback. It raises no read and no response, and `busy` falls in the cycle after `nlDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Primary miss: search for lookupAddr |
| lookupAddr | input | AW | Line address being searched |
| insValid | input | 1 | Primary cache evicts a line this cycle |
| insAddr | input | AW | Line address of the evicted line |
| insData | input | DW | Data of the evicted line |
| insDirty | input | 1 | Evicted line is modified |
| respValid | output | 1 | One-cycle response pulse |
| respHit | output | 1 | Response came from the buffer |
| respData | output | DW | Returned line data |
| respDirty | output | 1 | Returned line is modified |
| busy | output | 1 | Next-level transfer in progress |
| nlReq | output | 1 | Next-level request, held until nlDone |
| nlWrite | output | 1 | 1 = writeback, 0 = line read |
| nlAddr | output | AW | Next-level line address |
| nlWdata | output | DW | Writeback data |
| nlRdata | input | DW | Read data, valid with nlDone |
| nlDone | input | 1 | Next-level completion pulse |

## Verification
A corrupted tag, valid or dirty bit does not show at once. It shows at the next lookup of that address, as a wrong `respHit` in the following cycle, or as a spurious or missing writeback on `nlReq`. A wrong rotation pointer shows only after ENTRIES further pushes, when the wrong line is overwritten. The scenarios therefore fill the buffer completely, and then probe both the overwritten address and the surviving ones. A stuck control state shows within one cycle as `busy` or `nlReq` failing to drop after `nlDone`, or as a response that is missing or sent twice.

// File: rtl/vcPkg.sv
package vcPkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WB   = 2'd1,
    ST_RD   = 2'd2
  } vcState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic swapHit;    // lookup hit: return entry, refill or clear it
    logic pushIns;    // write insert line at rotating pointer
    logic latchMiss;  // capture missing line address
    logic fillResp;   // next-level read returned: respond with it
    logic selWb;      // next-level address comes from writeback register
  } vcStrobe_t;
endpackage

// File: rtl/vcDatapath.sv
module vcDatapath
  import vcPkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  vcStrobe_t     strb,
  input  logic [AW-1:0] lookupAddr,
  input  logic          insValid,
  input  logic [AW-1:0] insAddr,
  input  logic [DW-1:0] insData,
  input  logic          insDirty,
  input  logic [DW-1:0] nlRdata,
  output logic          hit,
  output logic          victimDirty,
  output logic          respValid,
  output logic          respHit,
  output logic [DW-1:0] respData,
  output logic          respDirty,
  output logic [AW-1:0] nlAddr,
  output logic [DW-1:0] nlWdata
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] entValid;
  logic [ENTRIES-1:0] entDirty;
  logic [AW-1:0]      entTag  [ENTRIES];
  logic [DW-1:0]      entData [ENTRIES];
  logic [ENTRIES-1:0] matchVec;
  logic [IW-1:0]      hitIdx;
  logic [IW-1:0]      wrPtr;
  logic [AW-1:0]      wbAddr;
  logic [DW-1:0]      wbData;
  logic [AW-1:0]      missAddr;

  // parallel tag compare
  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g] = entValid[g] && (entTag[g] == lookupAddr);
  end

  always_comb begin
    hitIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (matchVec[i]) hitIdx = IW'(i);
    end
  end

  assign hit         = |matchVec;
  assign victimDirty = entValid[wrPtr] && entDirty[wrPtr];

  // entry storage
  for (genvar g = 0; g < ENTRIES; g++) begin : gEnt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[g] <= 1'b0;
        entDirty[g] <= 1'b0;
        entTag[g]   <= '0;
        entData[g]  <= '0;
      end else if (strb.swapHit && matchVec[g]) begin
        if (insValid) begin
          entValid[g] <= 1'b1;
          entDirty[g] <= insDirty;
          entTag[g]   <= insAddr;
          entData[g]  <= insData;
        end else begin
          entValid[g] <= 1'b0;
        end
      end else if (strb.pushIns && (wrPtr == IW'(g))) begin
        entValid[g] <= 1'b1;
        entDirty[g] <= insDirty;
        entTag[g]   <= insAddr;
        entData[g]  <= insData;
      end
    end
  end

  // rotating pointer and captured displaced line
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      wbAddr   <= '0;
      wbData   <= '0;
      missAddr <= '0;
    end else begin
      if (strb.pushIns) begin
        wrPtr  <= (wrPtr == IW'(ENTRIES - 1)) ? '0 : wrPtr + 1'b1;
        wbAddr <= entTag[wrPtr];
        wbData <= entData[wrPtr];
      end
      if (strb.latchMiss) missAddr <= lookupAddr;
    end
  end

  // response register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respData  <= '0;
      respDirty <= 1'b0;
    end else begin
      respValid <= strb.swapHit || strb.fillResp;
      if (strb.swapHit) begin
        respHit   <= 1'b1;
        respData  <= entData[hitIdx];
        respDirty <= entDirty[hitIdx];
      end else if (strb.fillResp) begin
        respHit   <= 1'b0;
        respData  <= nlRdata;
        respDirty <= 1'b0;
      end
    end
  end

  assign nlAddr  = strb.selWb ? wbAddr : missAddr;
  assign nlWdata = wbData;
endmodule

// File: rtl/vcControl.sv
module vcControl
  import vcPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      lookupValid,
  input  logic      insValid,
  input  logic      hit,
  input  logic      victimDirty,
  input  logic      nlDone,
  output vcStrobe_t strb,
  output logic      busy,
  output logic      nlReq,
  output logic      nlWrite
);
  vcState_e state, stateNext;
  logic     readPend, readPendNext;

  always_comb begin
    strb         = '0;
    stateNext    = state;
    readPendNext = readPend;
    unique case (state)
      ST_IDLE: begin
        if (lookupValid && hit) begin
          strb.swapHit = 1'b1;
        end else if (lookupValid) begin
          strb.pushIns   = insValid;
          strb.latchMiss = 1'b1;
          readPendNext   = 1'b1;
          stateNext      = (insValid && victimDirty) ? ST_WB : ST_RD;
        end else if (insValid) begin
          strb.pushIns = 1'b1;
          readPendNext = 1'b0;
          if (victimDirty) stateNext = ST_WB;
        end
      end
      ST_WB: begin
        strb.selWb = 1'b1;
        if (nlDone) stateNext = readPend ? ST_RD : ST_IDLE;
      end
      ST_RD: begin
        if (nlDone) begin
          strb.fillResp = 1'b1;
          stateNext     = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      readPend <= 1'b0;
    end else begin
      state    <= stateNext;
      readPend <= readPendNext;
    end
  end

  assign busy    = (state != ST_IDLE);
  assign nlReq   = (state == ST_WB) || (state == ST_RD);
  assign nlWrite = (state == ST_WB);
endmodule

// File: rtl/victimCache.sv
module victimCache
  import vcPkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int ENTRIES = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lookupValid,
  input  logic [AW-1:0] lookupAddr,
  input  logic          insValid,
  input  logic [AW-1:0] insAddr,
  input  logic [DW-1:0] insData,
  input  logic          insDirty,
  output logic          respValid,
  output logic          respHit,
  output logic [DW-1:0] respData,
  output logic          respDirty,
  output logic          busy,
  output logic          nlReq,
  output logic          nlWrite,
  output logic [AW-1:0] nlAddr,
  output logic [DW-1:0] nlWdata,
  input  logic [DW-1:0] nlRdata,
  input  logic          nlDone
);
  vcStrobe_t strb;
  logic      hit;
  logic      victimDirty;

  vcControl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .insValid    (insValid),
    .hit         (hit),
    .victimDirty (victimDirty),
    .nlDone      (nlDone),
    .strb        (strb),
    .busy        (busy),
    .nlReq       (nlReq),
    .nlWrite     (nlWrite)
  );

  vcDatapath #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .lookupAddr  (lookupAddr),
    .insValid    (insValid),
    .insAddr     (insAddr),
    .insData     (insData),
    .insDirty    (insDirty),
    .nlRdata     (nlRdata),
    .hit         (hit),
    .victimDirty (victimDirty),
    .respValid   (respValid),
    .respHit     (respHit),
    .respData    (respData),
    .respDirty   (respDirty),
    .nlAddr      (nlAddr),
    .nlWdata     (nlWdata)
  );
endmodule

// File: rtl/vcChecker.sv
module vcChecker #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          lookupValid,
  input logic          insValid,
  input logic          respValid,
  input logic          respHit,
  input logic          respDirty,
  input logic [DW-1:0] respData,
  input logic [DW-1:0] nlRdata,
  input logic          busy,
  input logic          nlReq,
  input logic          nlWrite,
  input logic [AW-1:0] nlAddr,
  input logic          nlDone
);
  // R1: nothing on the next-level port or response after reset without stimulus
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !lookupValid && !insValid) |=> (!busy && !nlReq && !respValid));

  // R2: a hit response only follows an accepted lookup
  a_r2_hit_after_lookup: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> ($past(lookupValid) && !$past(busy)));

  // R5: request held with stable address until done
  a_r5_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (nlReq && !nlDone) |=> (nlReq && $stable(nlAddr) && $stable(nlWrite)));

  // R5: completed read yields a miss response with the returned data
  a_r5_fill_resp: assert property (@(posedge clk) disable iff (!rstN)
    (nlReq && !nlWrite && nlDone) |=>
      (respValid && !respHit && !respDirty && !busy && respData == $past(nlRdata)));

  // R9: a completed writeback never produces a response directly
  a_r9_wb_no_resp: assert property (@(posedge clk) disable iff (!rstN)
    (nlReq && nlWrite && nlDone) |=> !respValid);

  // R8: responses are never given while a transfer is still running
  a_r8_resp_idle: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !busy);
endmodule

bind victimCache vcChecker #(.AW(AW), .DW(DW)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .lookupValid (lookupValid),
  .insValid    (insValid),
  .respValid   (respValid),
  .respHit     (respHit),
  .respDirty   (respDirty),
  .respData    (respData),
  .nlRdata     (nlRdata),
  .busy        (busy),
  .nlReq       (nlReq),
  .nlWrite     (nlWrite),
  .nlAddr      (nlAddr),
  .nlDone      (nlDone)
);

// File: tb/victimCache_test.sv
module victimCache_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int ENTRIES = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic          insValid = 1'b0;
  logic [AW-1:0] insAddr = '0;
  logic [DW-1:0] insData = '0;
  logic          insDirty = 1'b0;
  logic          respValid, respHit, respDirty, busy, nlReq, nlWrite;
  logic [DW-1:0] respData, nlWdata;
  logic [AW-1:0] nlAddr;
  logic [DW-1:0] nlRdata = '0;
  logic          nlDone = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  victimCache #(.AW(AW), .DW(DW), .ENTRIES(ENTRIES)) uut (
    .clk(clk), .rstN(rstN),
    .lookupValid(lookupValid), .lookupAddr(lookupAddr),
    .insValid(insValid), .insAddr(insAddr), .insData(insData), .insDirty(insDirty),
    .respValid(respValid), .respHit(respHit), .respData(respData), .respDirty(respDirty),
    .busy(busy), .nlReq(nlReq), .nlWrite(nlWrite), .nlAddr(nlAddr), .nlWdata(nlWdata),
    .nlRdata(nlRdata), .nlDone(nlDone)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // one cycle of stimulus, sampled just after the accepting edge
  task automatic step(logic lv, logic [AW-1:0] la, logic iv,
                      logic [AW-1:0] ia, logic [DW-1:0] id, logic idirty);
    @(negedge clk);
    lookupValid = lv; lookupAddr = la;
    insValid = iv; insAddr = ia; insData = id; insDirty = idirty;
    @(posedge clk);
    #1;
    lookupValid = 1'b0; insValid = 1'b0;
  endtask

  // next-level model: expects a pending request now, completes it
  task automatic serve(string req, logic expWrite, logic [AW-1:0] expAddr,
                       logic [DW-1:0] expData, logic [DW-1:0] rdata);
    chk(req, "nlReq", 64'(nlReq), 64'(1));
    chk(req, "nlWrite", 64'(nlWrite), 64'(expWrite));
    chk(req, "nlAddr", 64'(nlAddr), 64'(expAddr));
    if (expWrite) chk(req, "nlWdata", 64'(nlWdata), 64'(expData));
    @(negedge clk);
    nlDone = 1'b1; nlRdata = rdata;
    @(posedge clk);
    #1;
    nlDone = 1'b0;
  endtask

  task automatic expectHit(string req, logic [AW-1:0] a, logic [DW-1:0] d, logic dirty);
    step(1'b1, a, 1'b0, '0, '0, 1'b0);
    chk(req, "respValid", 64'(respValid), 64'(1));
    chk(req, "respHit", 64'(respHit), 64'(1));
    chk(req, "respData", 64'(respData), 64'(d));
    chk(req, "respDirty", 64'(respDirty), 64'(dirty));
    chk(req, "nlReq on hit", 64'(nlReq), 64'(0));
  endtask

  task automatic expectMiss(string req, logic [AW-1:0] a, logic [DW-1:0] fill);
    step(1'b1, a, 1'b0, '0, '0, 1'b0);
    chk(req, "busy on miss", 64'(busy), 64'(1));
    chk(req, "respValid on miss", 64'(respValid), 64'(0));
    serve(req, 1'b0, a, '0, fill);
    chk(req, "fill respValid", 64'(respValid), 64'(1));
    chk(req, "fill respHit", 64'(respHit), 64'(0));
    chk(req, "fill respData", 64'(respData), 64'(fill));
    chk(req, "fill busy", 64'(busy), 64'(0));
  endtask

  task automatic testReset();
    doReset();
    #1;
    chk("R1", "busy after reset", 64'(busy), 64'(0));
    chk("R1", "nlReq after reset", 64'(nlReq), 64'(0));
    chk("R1", "respValid after reset", 64'(respValid), 64'(0));
    expectMiss("R1", 16'h0100, 32'hAAAA_0100);
    chk("R5", "respDirty on fill", 64'(respDirty), 64'(0));
  endtask

  task automatic testInsertHit();
    step(1'b0, '0, 1'b1, 16'h0010, 32'hD00D_0010, 1'b1);
    chk("R2", "busy after clean push", 64'(busy), 64'(0));
    expectHit("R2", 16'h0010, 32'hD00D_0010, 1'b1);
    expectMiss("R4", 16'h0010, 32'h1111_0010);
  endtask

  task automatic testSwap();
    step(1'b0, '0, 1'b1, 16'h0020, 32'hB0B0_0020, 1'b0);
    step(1'b1, 16'h0020, 1'b1, 16'h0030, 32'hC0C0_0030, 1'b1);
    chk("R3", "swap respHit", 64'(respHit), 64'(1));
    chk("R3", "swap respData", 64'(respData), 64'(32'hB0B0_0020));
    expectHit("R3", 16'h0030, 32'hC0C0_0030, 1'b1);
    expectMiss("R3", 16'h0020, 32'h2222_0020);
  endtask

  task automatic testFifoWriteback();
    doReset();
    for (int i = 0; i < ENTRIES; i++)
      step(1'b0, '0, 1'b1, 16'(16'h0040 + i), 32'(32'hE000_0000 + i), (i == 0));
    chk("R6", "busy after fill", 64'(busy), 64'(0));
    // miss with an eviction that overwrites the dirty oldest line
    step(1'b1, 16'h0099, 1'b1, 16'h0050, 32'hE000_0050, 1'b0);
    serve("R7", 1'b1, 16'h0040, 32'hE000_0000, '0);
    chk("R7", "no response after writeback", 64'(respValid), 64'(0));
    serve("R7", 1'b0, 16'h0099, '0, 32'h9999_0099);
    chk("R7", "fill respValid", 64'(respValid), 64'(1));
    chk("R7", "fill respData", 64'(respData), 64'(32'h9999_0099));
    // clean overwrite: no writeback
    step(1'b0, '0, 1'b1, 16'h0051, 32'hE000_0051, 1'b0);
    chk("R7", "clean overwrite busy", 64'(busy), 64'(0));
    chk("R7", "clean overwrite nlReq", 64'(nlReq), 64'(0));
    expectMiss("R6", 16'h0041, 32'h4141_0041);
    expectHit("R6", 16'h0042, 32'hE000_0002, 1'b0);
    expectHit("R6", 16'h0050, 32'hE000_0050, 1'b0);
    expectHit("R6", 16'h0051, 32'hE000_0051, 1'b0);
  endtask

  task automatic testStandaloneWb();
    doReset();
    for (int i = 0; i < ENTRIES; i++)
      step(1'b0, '0, 1'b1, 16'(16'h0060 + i), 32'(32'hF000_0000 + i), (i == 0));
    step(1'b0, '0, 1'b1, 16'h0070, 32'hF000_0070, 1'b0);
    chk("R9", "busy on dirty overwrite", 64'(busy), 64'(1));
    serve("R9", 1'b1, 16'h0060, 32'hF000_0000, '0);
    chk("R9", "busy after writeback", 64'(busy), 64'(0));
    chk("R9", "nlReq after writeback", 64'(nlReq), 64'(0));
    chk("R9", "respValid after writeback", 64'(respValid), 64'(0));
    expectHit("R9", 16'h0070, 32'hF000_0070, 1'b0);
  endtask

  task automatic testIgnoreBusy();
    doReset();
    step(1'b1, 16'h0200, 1'b0, '0, '0, 1'b0);
    chk("R8", "busy on miss", 64'(busy), 64'(1));
    step(1'b1, 16'h0210, 1'b1, 16'h0210, 32'h5555_0210, 1'b1);
    chk("R8", "nlAddr held while busy", 64'(nlAddr), 64'(16'h0200));
    chk("R8", "no response while busy", 64'(respValid), 64'(0));
    serve("R8", 1'b0, 16'h0200, '0, 32'h2020_0200);
    chk("R8", "resp data", 64'(respData), 64'(32'h2020_0200));
    expectMiss("R8", 16'h0210, 32'h3030_0210);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testInsertHit();
    testSwap();
    testFifoWriteback();
    testStandaloneWb();
    testIgnoreBusy();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule